// File: doc/BRIEF.md
# Block-Structured Boot Image Loader

This block takes a stream of 16-bit words, each qualified by a valid strobe, and reads it as a boot image. The first word is a key that must match a fixed value. A fixed run of reserved words follows and is thrown away. The next two words carry a 32-bit entry address, upper half first. After that come any number of data blocks. Each block has a word count, a 32-bit destination split into two words (upper half first), and then that many data words. The block writes each data word through a simple memory port to consecutive addresses.

A block whose count is zero ends the image. The block then raises a done flag and shows the captured entry address. If the key does not match, it raises a sticky error flag instead and ignores everything else until reset. Words may arrive with any number of idle cycles between them. The block works in one clock domain with a synchronous active-high reset. All of its outputs are registered.

Top module: `boot_stream_loader`

## Requirements
- R1: During and right after reset, wr_en, done and error are 0 and entry_point is 0.
- R2: The first accepted word must equal 0x08AA. For any other value, error goes to 1 in the cycle after that word is accepted and stays at 1 until reset. From then on, no write is made and done stays 0.
- R3: The eight words accepted after a matching key are discarded whatever their value. This holds even when they equal 0x0000 or the key. They cause no write and do not end the image.
- R4: The next two accepted words form the entry address: upper 16 bits first, then lower 16 bits. entry_point reads 0 until done rises and then shows {upper, lower}.
- R5: Each block starts with three header words: a data-word count, destination bits 31:16, and destination bits 15:0. None of the three causes a write.
- R6: Data word k of a block (counted from 0) is written with wr_addr = destination + k (modulo 2^32) and wr_data = the word. wr_en is high for exactly one cycle, in the cycle after that word is accepted.
- R7: The word after a block's last data word is the next block's count. A count of 0x0000 makes done go to 1 in the cycle after it is accepted, and done stays at 1 until reset.
- R8: Once done is 1, later words cause no write and change neither done, error nor entry_point.
- R9: A word is consumed only in a cycle where in_valid is 1. Idle cycles between any two words change nothing.
- R10: done and error are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_word | input | 16 | Incoming image word |
| in_valid | input | 1 | in_word is valid this cycle |
| wr_addr | output | 32 | Memory write address |
| wr_data | output | 16 | Memory write data |
| wr_en | output | 1 | Memory write strobe, one cycle per data word |
| done | output | 1 | Image fully loaded (sticky) |
| error | output | 1 | Key mismatch (sticky) |
| entry_point | output | 32 | Captured entry address, valid while done |

## Verification
The assertions check these properties on every cycle:
- each write strobe follows an accepted word;
- back-to-back writes have addresses that rise by one;
- done and error are sticky and never high together;
- no write happens while done or error is set;
- entry_point holds still once done is set.

Only the bench scenarios can show the rest, by comparing every output on every clock against a behavioural model of the image format:
- the key is matched against its exact value;
- eight reserved words are skipped, including ones that look like a key or a zero count;
- the address halves are put together in the right order;
- the address carries across the 16-bit boundary;
- zero-block images and idle gaps are handled.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  typedef enum logic [3:0] {
    ST_KEY,
    ST_RSVD,
    ST_EP_HI,
    ST_EP_LO,
    ST_LEN,
    ST_DST_HI,
    ST_DST_LO,
    ST_DATA,
    ST_DONE,
    ST_ERR
  } bsl_state_t;
endpackage

// File: rtl/bsl_counter.sv
module bsl_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         at_last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign at_last = (cnt_q == W'(1));
endmodule

// File: rtl/bsl_write_port.sv
module bsl_write_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_word,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en
);
  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_en   <= 1'b0;
    end else begin
      wr_en <= wr_req;
      if (base_load) begin
        ptr_q <= base_addr;
      end else if (wr_req) begin
        wr_addr <= ptr_q;
        wr_data <= wr_word;
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_stream_loader.sv
module boot_stream_loader
  import bsl_pkg::*;
#(
  parameter int          WORD_W     = 16,
  parameter int          RSVD_WORDS = 8,
  parameter logic [15:0] KEY        = 16'h08AA
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   in_word,
  input  logic                in_valid,
  output logic [2*WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic                wr_en,
  output logic                done,
  output logic                error,
  output logic [2*WORD_W-1:0] entry_point
);
  localparam int          PTR_W    = 2 * WORD_W;
  localparam bit          HAS_RSVD = (RSVD_WORDS > 0);
  localparam logic [WORD_W-1:0] RSVD_LD = WORD_W'(RSVD_WORDS);
  localparam logic [WORD_W-1:0] KEY_W   = WORD_W'(KEY);

  bsl_state_t        state_q, state_d;
  logic [WORD_W-1:0] ep_hi_q, ep_lo_q, dst_hi_q;
  logic              cnt_load, cnt_dec, cnt_last;
  logic [WORD_W-1:0] cnt_val;
  logic              wp_load, wp_req;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = in_word;
    cnt_dec  = 1'b0;
    wp_load  = 1'b0;
    wp_req   = 1'b0;
    if (in_valid) begin
      case (state_q)
        ST_KEY: begin
          cnt_load = 1'b1;
          cnt_val  = RSVD_LD;
          if (in_word != KEY_W) state_d = ST_ERR;
          else if (HAS_RSVD)    state_d = ST_RSVD;
          else                  state_d = ST_EP_HI;
        end
        ST_RSVD: begin
          cnt_dec = 1'b1;
          if (cnt_last) state_d = ST_EP_HI;
        end
        ST_EP_HI:  state_d = ST_EP_LO;
        ST_EP_LO:  state_d = ST_LEN;
        ST_LEN: begin
          if (in_word == '0) begin
            state_d = ST_DONE;
          end else begin
            cnt_load = 1'b1;
            state_d  = ST_DST_HI;
          end
        end
        ST_DST_HI: state_d = ST_DST_LO;
        ST_DST_LO: begin
          wp_load = 1'b1;
          state_d = ST_DATA;
        end
        ST_DATA: begin
          wp_req  = 1'b1;
          cnt_dec = 1'b1;
          if (cnt_last) state_d = ST_LEN;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_KEY;
      ep_hi_q     <= '0;
      ep_lo_q     <= '0;
      dst_hi_q    <= '0;
      done        <= 1'b0;
      error       <= 1'b0;
      entry_point <= '0;
    end else begin
      state_q <= state_d;
      done    <= (state_d == ST_DONE);
      error   <= (state_d == ST_ERR);
      if (in_valid && state_q == ST_EP_HI)  ep_hi_q  <= in_word;
      if (in_valid && state_q == ST_EP_LO)  ep_lo_q  <= in_word;
      if (in_valid && state_q == ST_DST_HI) dst_hi_q <= in_word;
      if (state_q == ST_LEN && state_d == ST_DONE)
        entry_point <= {ep_hi_q, ep_lo_q};
    end
  end

  bsl_counter #(.W(WORD_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .at_last  (cnt_last)
  );

  bsl_write_port #(.DATA_W(WORD_W), .ADDR_W(PTR_W)) u_wp (
    .clk       (clk),
    .rst       (rst),
    .base_load (wp_load),
    .base_addr ({dst_hi_q, in_word}),
    .wr_req    (wp_req),
    .wr_word   (in_word),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en)
  );
endmodule

// File: rtl/bsl_checker.sv
module bsl_checker #(
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2*WORD_W-1:0] wr_addr,
  input logic                wr_en,
  input logic                done,
  input logic                error,
  input logic [2*WORD_W-1:0] entry_point
);
  // R6
  wr_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(in_valid));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R2
  error_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    error |=> error);
  // R2
  no_write_on_error_chk: assert property (@(posedge clk) disable iff (rst)
    error |-> !wr_en);
  // R8
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);
  // R8
  entry_stable_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(entry_point));
  // R10
  done_error_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
endmodule

bind boot_stream_loader bsl_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .wr_addr     (wr_addr),
  .wr_en       (wr_en),
  .done        (done),
  .error       (error),
  .entry_point (entry_point)
);

// File: tb/boot_stream_loader_tb.sv
module boot_stream_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic [31:0] wr_addr, entry_point;
  logic [15:0] wr_data;
  logic        wr_en, done, error;

  int checks = 0;
  int errors = 0;
  int writes_seen = 0;

  always #2.5 clk = ~clk;

  boot_stream_loader u_dut (
    .clk(clk), .rst(rst), .in_word(in_word), .in_valid(in_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .done(done), .error(error), .entry_point(entry_point)
  );

  // Behavioural reference: phase names are strings of the format.
  string       m_phase;
  int          m_left;
  logic [31:0] m_ep, m_next;
  logic        e_wr, e_done, e_err;
  logic [31:0] e_addr, e_ep;
  logic [15:0] e_data;

  always @(posedge clk) begin
    e_wr = 1'b0;
    if (rst) begin
      m_phase = "key"; m_left = 0; m_ep = 0; m_next = 0;
      e_done = 0; e_err = 0; e_addr = 0; e_data = 0; e_ep = 0;
    end else if (in_valid) begin
      case (m_phase)
        "key": if (in_word == 16'h08AA) begin m_phase = "rsvd"; m_left = 8; end
               else begin m_phase = "dead"; e_err = 1; end
        "rsvd": begin m_left--; if (m_left == 0) m_phase = "ephi"; end
        "ephi": begin m_ep[31:16] = in_word; m_phase = "eplo"; end
        "eplo": begin m_ep[15:0] = in_word; m_phase = "len"; end
        "len": if (in_word == 0) begin m_phase = "dead"; e_done = 1; e_ep = m_ep; end
               else begin m_left = in_word; m_phase = "dhi"; end
        "dhi": begin m_next[31:16] = in_word; m_phase = "dlo"; end
        "dlo": begin m_next[15:0] = in_word; m_phase = "data"; end
        "data": begin
          e_wr = 1; e_addr = m_next; e_data = in_word;
          m_next = m_next + 1; m_left--;
          if (m_left == 0) m_phase = "len";
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(wr_en === e_wr, "R6", "wr_en", 32'(wr_en), 32'(e_wr));
      if (e_wr) begin
        writes_seen++;
        chk(wr_addr === e_addr, "R6", "wr_addr", wr_addr, e_addr);
        chk(wr_data === e_data, "R6", "wr_data", 32'(wr_data), 32'(e_data));
      end
      chk(done === e_done, "R7", "done", 32'(done), 32'(e_done));
      chk(error === e_err, "R2", "error", 32'(error), 32'(e_err));
      chk(entry_point === e_ep, "R4", "entry_point", entry_point, e_ep);
      chk(!(done && error), "R10", "done&error", 32'(done & error), 32'd0);
    end
  end

  task automatic send(input logic [15:0] w, input int gap);
    in_word = w; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; in_word = 16'hDEAD;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
    // R1 reset values
    chk(wr_en === 0 && done === 0 && error === 0 && entry_point === 0,
        "R1", "reset outputs", {wr_en, done, error, 29'd0}, 32'd0);
    rst = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic header(input logic [31:0] ep, input bit tricky);
    send(16'h08AA, 0);
    // R3 reserved words, some looking like key or zero length
    for (int i = 0; i < 8; i++)
      send(tricky ? ((i % 2 == 0) ? 16'h0000 : 16'h08AA) : 16'h1111 * 16'(i), i % 2);
    send(ep[31:16], 1);  // R4
    send(ep[15:0], 0);
  endtask

  task automatic block(input logic [31:0] dst, input int n, input logic [15:0] seed);
    send(16'(n), 0);     // R5
    send(dst[31:16], 2); // R9 idle gaps
    send(dst[15:0], 0);
    for (int i = 0; i < n; i++) send(seed + 16'(i * 3), i % 3);
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // Two blocks, second crosses a 16-bit boundary (R6 carry)
    header(32'h00BBCCDD, 1'b1);
    block(32'h1000_0000, 3, 16'hA000);
    block(32'h0000_FFFF, 2, 16'h5000);
    send(16'h0000, 2);
    chk(done === 1, "R7", "done after zero count", 32'(done), 32'd1);
    chk(entry_point === 32'h00BBCCDD, "R4", "entry", entry_point, 32'h00BBCCDD);
    chk(writes_seen == 5, "R6", "write count", 32'(writes_seen), 32'd5);
    // R8 words after done ignored
    send(16'h0003, 0); send(16'h0000, 0); send(16'h1234, 0); send(16'h5678, 1);
    chk(done === 1 && wr_en === 0, "R8", "post-done", 32'(done), 32'd1);
    chk(writes_seen == 5, "R8", "no writes after done", 32'(writes_seen), 32'd5);

    // R2 bad key then a valid-looking stream
    do_reset();
    send(16'h08AB, 1);
    chk(error === 1, "R2", "error on bad key", 32'(error), 32'd1);
    header(32'h1234_5678, 1'b0);
    block(32'h0000_0100, 2, 16'h7777);
    send(16'h0000, 1);
    chk(error === 1 && done === 0, "R2", "sticky error", {30'd0, done, error}, 32'd1);
    chk(writes_seen == 5, "R2", "no writes after error", 32'(writes_seen), 32'd5);

    // Empty image: zero count right after header
    do_reset();
    header(32'hCAFE_F00D, 1'b0);
    chk(done === 0, "R3", "not done after header", 32'(done), 32'd0);
    send(16'h0000, 1);
    chk(done === 1 && entry_point === 32'hCAFEF00D, "R7", "empty image",
        entry_point, 32'hCAFEF00D);

    // R9 long idle gaps in a single-word block
    do_reset();
    header(32'h0000_0042, 1'b0);
    send(16'h0001, 6);
    send(16'h2000, 6);
    send(16'h0010, 6);
    send(16'hBEEF, 6);
    chk(writes_seen == 6, "R9", "single write", 32'(writes_seen), 32'd6);
    send(16'h0000, 1);
    chk(entry_point === 32'h42, "R4", "entry small", entry_point, 32'h42);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule